// File: doc/BRIEF.md
# Fractional-Rate UART Transmitter

This block serialises 8-bit characters onto a single asynchronous line. Each character is framed as a low start bit, eight data bits with the least significant bit first, and a high stop bit. Every bit edge comes from one free-running clock through a down-counter, so the line changes only at precomputed cycle counts. No edge depends on other work in progress.

The bit period is given as an integer part `div_int` and a 16-bit fraction `div_frac`, in clock cycles. At the start of each bit, a phase accumulator adds the fraction. A carry out lengthens that bit by one cycle. Bit widths therefore alternate between the floor and the ceiling of the ideal period, and rounding error never builds up across a character. The accumulator is cleared when a character is accepted, so every frame with a given divisor has the same width pattern. Typical settings are 115200, 57600 or 19200 baud at clock rates of tens of MHz. For example, 694 + 29127/65536 cycles per bit gives 115200 baud from 80 MHz.

Characters enter through a valid/ready handshake. The divisor is captured together with the character.

Top module: `frac_uart_tx`

## Requirements
- R1: After reset, `tx_line` is 1 and `tx_ready` is 1.
- R2: A character is accepted at a rising edge where `tx_valid` and `tx_ready` are both 1. From the next cycle, `tx_ready` stays 0 for the whole frame.
- R3: A frame is a start bit at 0, then `tx_data` bits 0 to 7 in that order, then a stop bit at 1. `tx_line` changes only at a bit boundary or at acceptance.
- R4: Bits are numbered k = 0 (start) to 9 (stop). With I = `div_int` and F = `div_frac`, bit k begins at I*k + floor(k*F/65536) cycles after the accepting edge, and bit k+1 begins where bit k ends. Each bit therefore lasts I or I+1 cycles. The fractional phase restarts at zero in every frame.
- R5: A frame lasts exactly 10*I + floor(10*F/65536) cycles. `tx_ready` returns to 1 in the cycle after the stop bit ends.
- R6: `div_int` and `div_frac` are sampled at the accepting edge. Changes during a frame do not alter that frame.
- R7: `tx_valid` and `tx_data` while `tx_ready` is 0 are ignored. That character is never sent.
- R8: With F = 0, every bit lasts exactly I cycles. I = 1 is the smallest legal integer part, and it gives bits of 1 or 2 cycles.
- R9: Between frames, the line holds 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bit timing clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| div_int | input | 16 | Integer part of the bit period in cycles, at least 1 |
| div_frac | input | 16 | Fractional part of the bit period, in 1/65536 cycle units |
| tx_data | input | 8 | Character to send |
| tx_valid | input | 1 | Character offered |
| tx_ready | output | 1 | Idle and able to accept a character |
| tx_line | output | 1 | Serial output, idle high |

## Verification
Two events can fall in the same cycle. First, a bit boundary can coincide with a change of the divisor inputs. Second, the end of a stop bit can coincide with a new character being offered. The bench provokes both by rewriting the divisor and holding `tx_valid` with a different byte from early in a frame until just before it ends. It then checks every cycle of the line against the arithmetic boundary formula computed from the divisor that was presented at acceptance. Afterwards, idle cycles confirm that the held byte was never launched. A sweep over small integer parts, edge-case fractions and several bit patterns covers each pattern of carries between floor and ceiling widths.

// File: rtl/frac_uart_pkg.sv
package frac_uart_pkg;

  localparam int unsigned PHASE_W   = 16;
  localparam int unsigned CHAR_BITS = 8;

  // One accumulator step: {carry, new phase}
  function automatic logic [PHASE_W:0] phase_step(input logic [PHASE_W-1:0] acc,
                                                  input logic [PHASE_W-1:0] frac);
    return {1'b0, acc} + {1'b0, frac};
  endfunction

endpackage

// File: rtl/frac_bit_timer.sv
module frac_bit_timer #(
  parameter int unsigned INT_W  = 16,
  parameter int unsigned FRAC_W = frac_uart_pkg::PHASE_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic              active,
  input  logic [INT_W-1:0]  div_int,
  input  logic [FRAC_W-1:0] div_frac,
  output logic              bit_end
);
  import frac_uart_pkg::*;

  localparam int unsigned CNT_W = INT_W + 1;

  logic [INT_W-1:0]  int_q;
  logic [FRAC_W-1:0] frac_q;
  logic [FRAC_W-1:0] acc_q;
  logic [CNT_W-1:0]  cnt_q;

  logic [FRAC_W:0]   step;
  logic [INT_W-1:0]  next_int;
  logic [CNT_W-1:0]  next_cnt;

  assign bit_end  = active && (cnt_q == '0);
  assign next_int = load ? div_int : int_q;
  assign step     = phase_step(load ? '0 : acc_q, load ? div_frac : frac_q);
  assign next_cnt = {1'b0, next_int} + CNT_W'(step[FRAC_W]) - CNT_W'(1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      int_q  <= '0;
      frac_q <= '0;
      acc_q  <= '0;
      cnt_q  <= '0;
    end else if (load) begin
      int_q  <= div_int;
      frac_q <= div_frac;
      acc_q  <= step[FRAC_W-1:0];
      cnt_q  <= next_cnt;
    end else if (bit_end) begin
      acc_q  <= step[FRAC_W-1:0];
      cnt_q  <= next_cnt;
    end else if (active) begin
      cnt_q  <= cnt_q - CNT_W'(1);
    end
  end
endmodule

// File: rtl/frame_shifter.sv
module frame_shifter #(
  parameter int unsigned DATA_W = frac_uart_pkg::CHAR_BITS
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [DATA_W-1:0] data,
  input  logic              bit_end,
  output logic              line,
  output logic              busy,
  output logic              frame_done
);
  localparam int unsigned IDX_W = $clog2(DATA_W + 2);
  localparam logic [IDX_W-1:0] STOP_IDX = IDX_W'(DATA_W + 1);
  localparam logic [IDX_W-1:0] LAST_DATA = IDX_W'(DATA_W);

  logic [DATA_W-1:0] sr_q;
  logic [IDX_W-1:0]  idx_q;

  assign frame_done = bit_end && (idx_q == STOP_IDX);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sr_q  <= '0;
      idx_q <= '0;
      line  <= 1'b1;
      busy  <= 1'b0;
    end else if (load) begin
      sr_q  <= data;
      idx_q <= '0;
      line  <= 1'b0;
      busy  <= 1'b1;
    end else if (bit_end) begin
      if (idx_q == STOP_IDX) begin
        busy <= 1'b0;
        line <= 1'b1;
      end else if (idx_q == LAST_DATA) begin
        line  <= 1'b1;
        idx_q <= idx_q + IDX_W'(1);
      end else begin
        line  <= sr_q[0];
        sr_q  <= sr_q >> 1;
        idx_q <= idx_q + IDX_W'(1);
      end
    end
  end
endmodule

// File: rtl/frac_uart_tx.sv
module frac_uart_tx #(
  parameter int unsigned INT_W  = 16,
  parameter int unsigned FRAC_W = frac_uart_pkg::PHASE_W,
  parameter int unsigned DATA_W = frac_uart_pkg::CHAR_BITS
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [INT_W-1:0]  div_int,
  input  logic [FRAC_W-1:0] div_frac,
  input  logic [DATA_W-1:0] tx_data,
  input  logic              tx_valid,
  output logic              tx_ready,
  output logic              tx_line
);
  logic frame_start;
  logic bit_end;
  logic frame_done;
  logic busy;

  assign tx_ready    = !busy;
  assign frame_start = tx_valid && tx_ready;

  frac_bit_timer #(.INT_W(INT_W), .FRAC_W(FRAC_W)) timer_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (frame_start),
    .active   (busy),
    .div_int  (div_int),
    .div_frac (div_frac),
    .bit_end  (bit_end)
  );

  frame_shifter #(.DATA_W(DATA_W)) shifter_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .load       (frame_start),
    .data       (tx_data),
    .bit_end    (bit_end),
    .line       (tx_line),
    .busy       (busy),
    .frame_done (frame_done)
  );
endmodule

// File: rtl/frac_uart_tx_chk.sv
module frac_uart_tx_chk #(
  parameter int unsigned INT_W = 16
) (
  input logic             clk,
  input logic             rst_n,
  input logic [INT_W-1:0] div_int,
  input logic             tx_ready,
  input logic             tx_line,
  input logic             frame_start,
  input logic             bit_end,
  input logic             frame_done
);
  localparam int unsigned RUN_W = INT_W + 2;

  logic [RUN_W-1:0] run_q;
  logic [RUN_W-1:0] lat_int_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_q     <= '0;
      lat_int_q <= '0;
    end else begin
      if (frame_start) lat_int_q <= RUN_W'(div_int);
      if (frame_start || bit_end) run_q <= RUN_W'(1);
      else if (!tx_ready)         run_q <= run_q + RUN_W'(1);
    end
  end

  AST_IDLE_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
    tx_ready |-> tx_line); // R9

  AST_ACCEPT_START: assert property (@(posedge clk) disable iff (!rst_n)
    frame_start |=> (!tx_line && !tx_ready)); // R2

  AST_LINE_AT_BOUNDARY: assert property (@(posedge clk) disable iff (!rst_n)
    (!bit_end && !frame_start) |=> $stable(tx_line)); // R3

  AST_BIT_WIDTH: assert property (@(posedge clk) disable iff (!rst_n)
    bit_end |-> (run_q == lat_int_q || run_q == lat_int_q + RUN_W'(1))); // R4

  AST_DONE_READY: assert property (@(posedge clk) disable iff (!rst_n)
    frame_done |=> tx_ready); // R5

  AST_STOP_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
    frame_done |-> tx_line); // R3
endmodule

bind frac_uart_tx frac_uart_tx_chk #(.INT_W(INT_W)) chk_i (
  .clk         (clk),
  .rst_n       (rst_n),
  .div_int     (div_int),
  .tx_ready    (tx_ready),
  .tx_line     (tx_line),
  .frame_start (frame_start),
  .bit_end     (bit_end),
  .frame_done  (frame_done)
);

// File: tb/frac_uart_tx_tb_top.sv
module frac_uart_tx_tb_top;
  logic        clk = 1'b0;
  logic        rst_n;
  logic [15:0] div_int;
  logic [15:0] div_frac;
  logic [7:0]  tx_data;
  logic        tx_valid;
  logic        tx_ready;
  logic        tx_line;

  int checks = 0;
  int fails  = 0;
  int cyc    = 0;

  always #2 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  frac_uart_tx dut_i (
    .clk(clk), .rst_n(rst_n), .div_int(div_int), .div_frac(div_frac),
    .tx_data(tx_data), .tx_valid(tx_valid), .tx_ready(tx_ready), .tx_line(tx_line)
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  // Start cycle of bit k relative to the accepting edge
  function automatic longint edge_at(input int k, input longint i, input longint f);
    return k * i + ((k * f) / 65536);
  endfunction

  function automatic bit bit_value(input int k, input logic [7:0] d);
    if (k == 0) return 1'b0;
    if (k == 9) return 1'b1;
    return d[k-1];
  endfunction

  // Send one frame and compare every cycle; disturb=1 rewrites divisor and offers another byte
  task automatic run_frame(input logic [7:0] d, input int i, input int f,
                           input bit disturb, input string req);
    longint total;
    int     bad_line = 0, bad_ready = 0, first_n = -1, first_act = 0, first_exp = 0;
    int     k;
    @(negedge clk);
    div_int  = 16'(i);
    div_frac = 16'(f);
    tx_data  = d;
    tx_valid = 1'b1;
    chk(tx_ready == 1'b1, "R2", "ready before accept", tx_ready, 1);
    @(negedge clk);
    tx_valid = 1'b0;
    total = edge_at(10, i, f);
    k = 0;
    for (int n = 0; n < total; n++) begin
      while (edge_at(k + 1, i, f) <= n) k++;
      if (tx_line !== bit_value(k, d)) begin
        bad_line++;
        if (first_n < 0) begin first_n = n; first_act = tx_line; first_exp = bit_value(k, d); end
      end
      if (tx_ready !== 1'b0) bad_ready++;
      if (disturb && n == 1) begin
        div_int  = 16'(i + 3);
        div_frac = 16'(f) ^ 16'h8000;
        tx_data  = ~d;
        tx_valid = 1'b1;
      end
      if (n == total - 1) tx_valid = 1'b0;
      @(negedge clk);
    end
    chk(bad_line == 0, req, $sformatf("line mismatch count (first at cycle %0d, got %0d want %0d), I=%0d F=%0d d=%02h",
        first_n, first_act, first_exp, i, f, d), bad_line, 0);
    chk(bad_ready == 0, "R2", "cycles with ready high inside frame", bad_ready, 0);
    chk(tx_ready == 1'b1, "R5", "ready the cycle after stop bit", tx_ready, 1);
    chk(tx_line == 1'b1, "R9", "line high after frame", tx_line, 1);
    div_int  = 16'(i);
    div_frac = 16'(f);
    if (disturb) begin
      int bad_idle = 0;
      for (int n = 0; n < 2 * i + 4; n++) begin
        @(negedge clk);
        if (tx_line !== 1'b1 || tx_ready !== 1'b1) bad_idle++;
      end
      chk(bad_idle == 0, "R7", "idle cycles disturbed by byte offered while busy", bad_idle, 0);
    end
  endtask

  initial begin : watchdog
    wait (cyc >= 190000);
    checks++;
    fails++;
    $display("FAIL watchdog expired at cycle %0d, expected end before 190000", cyc);
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin : main
    int flist[6];
    logic [7:0] dlist[4];
    flist = '{0, 1, 16384, 32768, 21846, 65535};
    dlist = '{8'h00, 8'hFF, 8'h55, 8'hA6};
    rst_n    = 1'b0;
    tx_valid = 1'b0;
    tx_data  = 8'h00;
    div_int  = 16'd4;
    div_frac = 16'd0;
    repeat (3) @(negedge clk);
    chk(tx_line == 1'b1, "R1", "line in reset", tx_line, 1);
    chk(tx_ready == 1'b1, "R1", "ready in reset", tx_ready, 1);
    rst_n = 1'b1;
    @(negedge clk);
    chk(tx_line == 1'b1 && tx_ready == 1'b1, "R1", "idle after reset release",
        {tx_line, tx_ready}, 3);

    // R4 sweep over small integer parts, edge fractions and bit patterns; R8 at F=0 and I=1
    for (int ii = 1; ii <= 3; ii++)
      for (int fi = 0; fi < 6; fi++)
        for (int di = 0; di < 4; di++)
          run_frame(dlist[di], ii, flist[fi], 1'b0,
                    (flist[fi] == 0 || ii == 1) ? "R8" : "R4");

    // R6 and R7: divisor rewritten and another byte offered mid-frame
    run_frame(8'h3C, 5, 36864, 1'b1, "R6");
    run_frame(8'hC5, 2, 65535, 1'b1, "R6");

    // R4/R5 at realistic divisors (115200 and 57600 baud from 80 MHz)
    run_frame(8'h4B, 694, 29127, 1'b0, "R4");
    run_frame(8'hB2, 1388, 58254, 1'b0, "R5");

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule